// File: doc/BRIEF.md
# Programmable Magnetic Switch/Latch Decision

This block is the decision core of a two-wire magnetic position sensor. It takes signed field samples and temperature samples, each with its own valid strobe. From them it produces a 2-bit code that tells the current sink which supply-current level to draw: a safe low level, one of two low levels, or the high level.

Parallel configuration inputs set the behaviour:
- the operate-point magnitude;
- the magnet polarity;
- the mode: unipolar switch, omnipolar switch or latch;
- the switch hysteresis;
- the output polarity;
- the low-current choice;
- a temperature-coefficient code.

Both switching thresholds are scaled with the most recently accepted temperature. The scaling tracks the field drift of the selected magnet material.

Until configuration is valid, and whenever the supply is in lockout, the output is the power-on state (high current). After that, the output stays at the power-on state until the field first leaves the hysteresis band. A configuration integrity error forces the safe state, and so does a junction temperature above the trip point. The overtemperature flag has its own hysteresis.

Top module: `hall_decide`

## Requirements
- R1: While `cfg_ok` is 0 or `uv` is 1, the output is HIGH (code 11). The output is also HIGH out of reset. Either condition also clears any decided field state.
- R2: Output codes are SAFE=00, LOW1=01, LOW2=10 and HIGH=11. A low output is LOW1 when `low_sel`=0 and LOW2 when `low_sel`=1.
- R3: With `out_pol`=0, field-present gives HIGH and field-absent gives low. With `out_pol`=1, the mapping is swapped.
- R4: Unipolar switch (`sel_unipolar`=1, `sel_latch`=0), decided on a field strobe:
  - With `mag_pol`=0 (south), the field becomes present when B >= OP and absent when B < RP.
  - With `mag_pol`=1 (north), it becomes present when B <= -OP and absent when B > -RP.
  - Otherwise the previous decision holds.
- R5: Omnipolar switch (`sel_unipolar`=0, `sel_latch` ignored): the field becomes present when |B| >= OP and absent when -RP < B < RP.
- R6: Latch (both select bits 1): `hys_code` is ignored and the release point mirrors the operate point.
  - With `mag_pol`=0, present when B >= OP and absent when B <= -OP.
  - With `mag_pol`=1, the two conditions are swapped.
  - If both hold, present wins.
- R7: In switch modes, the uncompensated operate point is 3 × `op_code` G. The uncompensated release point is that value minus 3 × `hys_code` G, saturated at 0.
- R8: Each threshold T is compensated as T − floor(T × K × (t − 25) / 65536), clamped to 0..2047, where t is the last temperature accepted on an earlier strobe. K is 0, 23, 79 or 131 for `tc_code` 00, 01, 10 and 11. Examples with T=81 and `tc_code`=11: 61 G at 150 °C and 92 G at −40 °C.
- R9: After power-on, the output stays HIGH until the first field strobe that meets an operate or release condition. Samples inside the hysteresis band leave it HIGH.
- R10: With configuration valid and no lockout, `cfg_err`=1 forces SAFE.
- R11: Overtemperature sets on a temperature strobe with t > 205 and clears on a strobe with t <= 180. While it is set, the output is SAFE (R1 takes priority).
- R12: A field or temperature strobe affects the output at the first rising clock edge that samples it. Without a strobe, the field state and the overtemperature state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ok | input | 1 | Configuration loaded and valid |
| cfg_err | input | 1 | Configuration integrity error |
| uv | input | 1 | Supply below lockout level |
| field_vld | input | 1 | Field sample strobe |
| field | input | 12 | Signed field sample, 1 G/LSB, negative means north |
| temp_vld | input | 1 | Temperature sample strobe |
| temp | input | 9 | Signed temperature, 1 °C/LSB |
| op_code | input | 8 | Operate-point magnitude, 3 G per step |
| mag_pol | input | 1 | Magnet polarity: 0 south, 1 north |
| sel_unipolar | input | 1 | Mode select bit: 0 omnipolar |
| sel_latch | input | 1 | Latch select when unipolar bit is 1 |
| hys_code | input | 5 | Switch hysteresis, 3 G per step |
| out_pol | input | 1 | Output polarity: 0 standard, 1 reversed |
| low_sel | input | 1 | Low-current level choice |
| tc_code | input | 2 | Temperature-coefficient code |
| state_code | output | 2 | Supply-current state code |

## Verification
The hardest situation to reach is the held power-on state. The first valid field sample must land strictly between release and operate, with the thresholds shifted by whatever temperature was accepted last. The directed phase reaches it by fixing the temperature at 25 °C, choosing a hysteresis that opens a wide band, and sending an in-band sample right after configuration becomes valid. It repeats this after a lockout pulse while in latch mode. The random phase reshuffles configuration and lockout often and mixes stray temperature strobes among the field strobes, so many other band entries happen with compensated thresholds. Directed steps also put strobes on the exact overtemperature set and clear temperatures and on compensated threshold values.

// File: rtl/hall_decide_pkg.sv
package hall_decide_pkg;

  typedef enum logic [1:0] {
    ST_SAFE = 2'b00,
    ST_LOW1 = 2'b01,
    ST_LOW2 = 2'b10,
    ST_HIGH = 2'b11
  } cur_state_e;

  typedef enum logic [1:0] {
    MD_OMNI  = 2'd0,
    MD_UNI   = 2'd1,
    MD_LATCH = 2'd2
  } cmp_mode_e;

  // Drift coefficient magnitude per degree, Q16 fraction.
  function automatic int unsigned tc_q16(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 23;
      2'd2:    return 79;
      default: return 131;
    endcase
  endfunction

endpackage

// File: rtl/hall_tcomp.sv
module hall_tcomp
  import hall_decide_pkg::*;
#(
  parameter int MAG_W  = 11,
  parameter int TEMP_W = 9,
  parameter int FRAC   = 16,
  parameter int T_REF  = 25
) (
  input  logic [MAG_W-1:0]         t25,
  input  logic [1:0]               tc_code,
  input  logic signed [TEMP_W-1:0] temp,
  output logic [MAG_W-1:0]         thr
);
  localparam int PW = MAG_W + TEMP_W + 12;
  localparam logic signed [PW-1:0] MAXV = PW'((1 << MAG_W) - 1);

  logic signed [PW-1:0] dt, coef, base, prod, delta, adj;

  always_comb begin
    dt    = $signed({{(PW-TEMP_W){temp[TEMP_W-1]}}, temp}) - PW'(T_REF);
    coef  = $signed(PW'(tc_q16(tc_code)));
    base  = $signed({{(PW-MAG_W){1'b0}}, t25});
    prod  = base * coef * dt;
    delta = prod >>> FRAC;
    adj   = base - delta;
    if (adj < 0)         thr = '0;
    else if (adj > MAXV) thr = MAXV[MAG_W-1:0];
    else                 thr = adj[MAG_W-1:0];
  end

endmodule

// File: rtl/hall_otmon.sv
module hall_otmon #(
  parameter int TEMP_W = 9,
  parameter int OT_SET = 205,
  parameter int OT_HYS = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     temp_vld,
  input  logic signed [TEMP_W-1:0] temp,
  output logic                     ot_d,
  output logic                     ot_q
);
  localparam int OT_CLR = OT_SET - OT_HYS;

  always_comb begin
    ot_d = ot_q;
    if (temp_vld) begin
      if (temp > OT_SET)       ot_d = 1'b1;
      else if (temp <= OT_CLR) ot_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ot_q <= 1'b0;
    else if (temp_vld) ot_q <= ot_d;
  end

endmodule

// File: rtl/hall_hyst.sv
module hall_hyst
  import hall_decide_pkg::*;
#(
  parameter int FIELD_W = 12,
  parameter int MAG_W   = FIELD_W - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hold_pos,
  input  logic                      field_vld,
  input  logic signed [FIELD_W-1:0] field,
  input  cmp_mode_e                 mode,
  input  logic                      mag_pol,
  input  logic [MAG_W-1:0]          op_thr,
  input  logic [MAG_W-1:0]          rp_thr,
  output logic                      known_d,
  output logic                      present_d
);
  logic known_q, present_q;
  logic signed [FIELD_W-1:0] opv, rpv;
  logic s_op, n_op, s_rel, n_rel, op_hit, rel_hit;

  always_comb begin
    opv   = $signed({1'b0, op_thr});
    rpv   = $signed({1'b0, rp_thr});
    s_op  = field >= opv;
    n_op  = field <= -opv;
    s_rel = field < rpv;
    n_rel = field > -rpv;
    case (mode)
      MD_OMNI: begin
        op_hit  = s_op | n_op;
        rel_hit = s_rel & n_rel;
      end
      MD_LATCH: begin
        op_hit  = mag_pol ? n_op : s_op;
        rel_hit = mag_pol ? s_op : n_op;
      end
      default: begin
        op_hit  = mag_pol ? n_op : s_op;
        rel_hit = mag_pol ? n_rel : s_rel;
      end
    endcase
  end

  always_comb begin
    known_d   = known_q;
    present_d = present_q;
    if (hold_pos) begin
      known_d   = 1'b0;
      present_d = 1'b0;
    end else if (field_vld) begin
      if (op_hit) begin
        known_d   = 1'b1;
        present_d = 1'b1;
      end else if (rel_hit) begin
        known_d   = 1'b1;
        present_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known_q   <= 1'b0;
      present_q <= 1'b0;
    end else if (hold_pos || field_vld) begin
      known_q   <= known_d;
      present_q <= present_d;
    end
  end

endmodule

// File: rtl/hall_decide.sv
module hall_decide
  import hall_decide_pkg::*;
#(
  parameter int FIELD_W  = 12,
  parameter int TEMP_W   = 9,
  parameter int OP_W     = 8,
  parameter int HYS_W    = 5,
  parameter int OP_STEP  = 3,
  parameter int HYS_STEP = 3,
  parameter int FRAC     = 16,
  parameter int T_REF    = 25,
  parameter int OT_SET   = 205,
  parameter int OT_HYS   = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_ok,
  input  logic                      cfg_err,
  input  logic                      uv,
  input  logic                      field_vld,
  input  logic signed [FIELD_W-1:0] field,
  input  logic                      temp_vld,
  input  logic signed [TEMP_W-1:0]  temp,
  input  logic [OP_W-1:0]           op_code,
  input  logic                      mag_pol,
  input  logic                      sel_unipolar,
  input  logic                      sel_latch,
  input  logic [HYS_W-1:0]          hys_code,
  input  logic                      out_pol,
  input  logic                      low_sel,
  input  logic [1:0]                tc_code,
  output logic [1:0]                state_code
);
  localparam int MAG_W = FIELD_W - 1;
  localparam int NTHR  = 2;

  logic       rst_m_n, rst_s_n;
  logic signed [TEMP_W-1:0] temp_q;
  cmp_mode_e  mode;
  logic       hold_pos, known_d, present_d, ot_d, ot_q;
  int         op25, rel25;
  logic [MAG_W-1:0] t25_a [NTHR];
  logic [MAG_W-1:0] thr_a [NTHR];
  cur_state_e st_d, st_q;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      temp_q <= TEMP_W'(T_REF);
    else if (temp_vld) temp_q <= temp;
  end

  always_comb begin
    if (!sel_unipolar)  mode = MD_OMNI;
    else if (sel_latch) mode = MD_LATCH;
    else                mode = MD_UNI;
  end

  always_comb begin
    op25  = int'(op_code) * OP_STEP;
    rel25 = op25 - int'(hys_code) * HYS_STEP;
    if (mode == MD_LATCH || rel25 < 0) rel25 = (mode == MD_LATCH) ? op25 : 0;
    t25_a[0] = MAG_W'(op25);
    t25_a[1] = MAG_W'(rel25);
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_comp
    hall_tcomp #(
      .MAG_W (MAG_W),
      .TEMP_W(TEMP_W),
      .FRAC  (FRAC),
      .T_REF (T_REF)
    ) u_tcomp (
      .t25    (t25_a[g]),
      .tc_code(tc_code),
      .temp   (temp_q),
      .thr    (thr_a[g])
    );
  end

  assign hold_pos = uv | ~cfg_ok;

  hall_hyst #(
    .FIELD_W(FIELD_W),
    .MAG_W  (MAG_W)
  ) u_hyst (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .hold_pos (hold_pos),
    .field_vld(field_vld),
    .field    (field),
    .mode     (mode),
    .mag_pol  (mag_pol),
    .op_thr   (thr_a[0]),
    .rp_thr   (thr_a[1]),
    .known_d  (known_d),
    .present_d(present_d)
  );

  hall_otmon #(
    .TEMP_W(TEMP_W),
    .OT_SET(OT_SET),
    .OT_HYS(OT_HYS)
  ) u_otmon (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .temp_vld(temp_vld),
    .temp    (temp),
    .ot_d    (ot_d),
    .ot_q    (ot_q)
  );

  always_comb begin
    if (hold_pos)                 st_d = ST_HIGH;
    else if (cfg_err || ot_d)     st_d = ST_SAFE;
    else if (!known_d)            st_d = ST_HIGH;
    else if (present_d ^ out_pol) st_d = ST_HIGH;
    else                          st_d = low_sel ? ST_LOW2 : ST_LOW1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) st_q <= ST_HIGH;
    else          st_q <= st_d;
  end

  assign state_code = st_q;

endmodule

// File: rtl/hall_decide_chk.sv
module hall_decide_chk #(
  parameter int TEMP_W = 9,
  parameter int OT_SET = 205
) (
  input logic                     clk,
  input logic                     rst_ok,
  input logic                     cfg_ok,
  input logic                     cfg_err,
  input logic                     uv,
  input logic                     low_sel,
  input logic                     temp_vld,
  input logic signed [TEMP_W-1:0] temp,
  input logic [1:0]               state_code
);
  AST_POS_HIGH: assert property (@(posedge clk) disable iff (!rst_ok)
    (uv || !cfg_ok) |=> (state_code == 2'b11)); // R1

  AST_LOW1_ONLY: assert property (@(posedge clk) disable iff (!rst_ok)
    (!low_sel) |=> (state_code != 2'b10)); // R2

  AST_LOW2_ONLY: assert property (@(posedge clk) disable iff (!rst_ok)
    (low_sel) |=> (state_code != 2'b01)); // R2

  AST_CFG_SAFE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_ok && !uv && cfg_err) |=> (state_code == 2'b00)); // R10

  AST_OT_SAFE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_ok && !uv && temp_vld && (temp > OT_SET)) |=> (state_code == 2'b00)); // R11

endmodule

bind hall_decide hall_decide_chk #(
  .TEMP_W(TEMP_W),
  .OT_SET(OT_SET)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_s_n),
  .cfg_ok    (cfg_ok),
  .cfg_err   (cfg_err),
  .uv        (uv),
  .low_sel   (low_sel),
  .temp_vld  (temp_vld),
  .temp      (temp),
  .state_code(state_code)
);

// File: tb/hall_decide_bench.sv
`timescale 1ns/1ps
module hall_decide_bench;
  logic clk = 1'b0;
  logic rst_n, cfg_ok, cfg_err, uv, field_vld, temp_vld;
  logic signed [11:0] field;
  logic signed [8:0]  temp;
  logic [7:0] op_code;
  logic [4:0] hys_code;
  logic [1:0] tc_code;
  logic mag_pol, sel_unipolar, sel_latch, out_pol, low_sel;
  logic [1:0] state_code;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit m_known, m_present, m_ot;
  int m_temp;

  always #2.5 clk = ~clk;

  hall_decide u_hall_decide (
    .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok), .cfg_err(cfg_err), .uv(uv),
    .field_vld(field_vld), .field(field), .temp_vld(temp_vld), .temp(temp),
    .op_code(op_code), .mag_pol(mag_pol), .sel_unipolar(sel_unipolar),
    .sel_latch(sel_latch), .hys_code(hys_code), .out_pol(out_pol),
    .low_sel(low_sel), .tc_code(tc_code), .state_code(state_code)
  );

  function automatic int comp(input int t25, input logic [1:0] c, input int t);
    int k, d;
    k = (c == 2'd0) ? 0 : (c == 2'd1) ? 23 : (c == 2'd2) ? 79 : 131;
    d = (t25 * k * (t - 25)) >>> 16;
    d = t25 - d;
    if (d < 0) d = 0;
    if (d > 2047) d = 2047;
    return d;
  endfunction

  function automatic logic [1:0] exp_out();
    if (uv || !cfg_ok) return 2'b11;
    if (cfg_err || m_ot) return 2'b00;
    if (!m_known) return 2'b11;
    if (m_present ^ out_pol) return 2'b11;
    return low_sel ? 2'b10 : 2'b01;
  endfunction

  task automatic model(input int f, input bit fv, input int t, input bit tv);
    int op, rp, r25;
    bit oh, rh;
    op  = comp(int'(op_code) * 3, tc_code, m_temp);
    r25 = int'(op_code) * 3 - int'(hys_code) * 3;
    if (r25 < 0) r25 = 0;
    rp  = comp(r25, tc_code, m_temp);
    if (!sel_unipolar) begin
      oh = (f >= op) || (f <= -op);
      rh = (f < rp) && (f > -rp);
    end else if (sel_latch) begin
      oh = mag_pol ? (f <= -op) : (f >= op);
      rh = mag_pol ? (f >= op) : (f <= -op);
    end else begin
      oh = mag_pol ? (f <= -op) : (f >= op);
      rh = mag_pol ? (f > -rp) : (f < rp);
    end
    if (uv || !cfg_ok) begin
      m_known = 0; m_present = 0;
    end else if (fv) begin
      if (oh) begin m_known = 1; m_present = 1; end
      else if (rh) begin m_known = 1; m_present = 0; end
    end
    if (tv) begin
      if (t > 205) m_ot = 1;
      else if (t <= 180) m_ot = 0;
      m_temp = t;
    end
  endtask

  task automatic step(input int f, input bit fv, input int t, input bit tv);
    @(negedge clk);
    field = 12'(f); field_vld = fv; temp = 9'(t); temp_vld = tv;
    model(f, fv, t, tv);
    @(negedge clk);
    field_vld = 0; temp_vld = 0;
  endtask

  task automatic chk(input string tag, input logic [1:0] exp);
    n_chk++;
    if (state_code !== exp) begin
      n_err++;
      $display("FAIL %s: state_code=%b expected=%b", tag, state_code, exp);
    end
  endtask

  task automatic fstep(input string tag, input int f, input logic [1:0] exp);
    step(f, 1, 0, 0);
    chk(tag, exp);
    chk({tag, " model"}, exp_out());
  endtask

  task automatic tstep(input int t);
    step(0, 0, t, 1);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: state_code=%b expected=finish", state_code);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cfg_ok = 0; cfg_err = 0; uv = 0; field_vld = 0; temp_vld = 0;
    field = 0; temp = 25; op_code = 8'd27; hys_code = 5'd5; tc_code = 2'd3;
    mag_pol = 0; sel_unipolar = 1; sel_latch = 0; out_pol = 0; low_sel = 0;
    m_known = 0; m_present = 0; m_ot = 0; m_temp = 25;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset", 2'b11);
    step(200, 1, 0, 0);
    chk("R1 cfg not valid", 2'b11);

    cfg_ok = 1;
    tstep(25);
    fstep("R9 in-band first sample", 70, 2'b11);
    fstep("R9 release excursion", 50, 2'b01);
    fstep("R7 band hold low", 70, 2'b01);
    fstep("R4 south operate", 81, 2'b11);
    fstep("R7 band hold high", 70, 2'b11);
    fstep("R7 below release", 65, 2'b01);
    low_sel = 1;
    fstep("R2 low2", 60, 2'b10);
    out_pol = 1;
    fstep("R3 reversed present", 90, 2'b10);
    fstep("R3 reversed absent", 0, 2'b11);
    out_pol = 0; low_sel = 0; hys_code = 0;
    tstep(150);
    fstep("R8 hot operate", 61, 2'b11);
    fstep("R8 hot release", 60, 2'b01);
    tstep(-40);
    fstep("R8 cold below", 91, 2'b01);
    fstep("R8 cold operate", 92, 2'b11);
    tstep(25);
    mag_pol = 1;
    fstep("R4 north ignores south", 100, 2'b01);
    fstep("R4 north operate", -81, 2'b11);
    sel_unipolar = 0; mag_pol = 0;
    fstep("R5 omni south", 81, 2'b11);
    fstep("R5 omni release", -50, 2'b01);
    fstep("R5 omni north", -81, 2'b11);
    sel_unipolar = 1; sel_latch = 1; hys_code = 5'd31;
    fstep("R6 latch operate", 81, 2'b11);
    fstep("R6 latch zero hold", 0, 2'b11);
    fstep("R6 latch near mirror", -80, 2'b11);
    fstep("R6 latch release", -81, 2'b01);
    cfg_err = 1;
    fstep("R10 integrity error", 81, 2'b00);
    cfg_err = 0;
    step(0, 0, 0, 0);
    chk("R10 error cleared", exp_out());
    tstep(205);
    chk("R11 at trip not set", 2'b11);
    tstep(206);
    chk("R11 overtemp set", 2'b00);
    tstep(181);
    chk("R11 still set", 2'b00);
    tstep(180);
    chk("R11 cleared", 2'b11);
    step(-500, 0, 25, 0);
    chk("R12 no strobe no change", 2'b11);
    uv = 1;
    step(0, 0, 0, 0);
    chk("R1 lockout", 2'b11);
    uv = 0;
    fstep("R9 band after lockout", 0, 2'b11);
    fstep("R9 latch release after lockout", -90, 2'b01);

    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 0) begin
        op_code = 8'($urandom_range(0, 200));
        hys_code = 5'($urandom);
        tc_code = 2'($urandom);
        mag_pol = 1'($urandom);
        sel_unipolar = 1'($urandom);
        sel_latch = 1'($urandom);
        out_pol = 1'($urandom);
        low_sel = 1'($urandom);
        cfg_err = ($urandom_range(0, 19) == 0);
        uv = ($urandom_range(0, 19) == 0);
        cfg_ok = ($urandom_range(0, 19) != 0);
      end
      if (i % 150 == 75) uv = 0;
      begin
        int f, t;
        bit tv;
        f = int'($urandom_range(0, 1200)) - 600;
        tv = ($urandom_range(0, 9) == 0);
        t = int'($urandom_range(0, 290)) - 60;
        step(f, 1, t, tv);
        chk("R12 random decision", exp_out());
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule